// File: doc/BRIEF.md
# Reloadable Down-Counting Pulse Timer

This block is a down-counter with a reload register and a toggling output. It has two modes. In continuous mode it reloads after every underflow and produces a square wave. In single-shot mode it stops after one underflow and produces a single pulse. The counter advances only on count ticks. These come from a prescaler that divides the system clock by 1, 2, 4 or 8.

Counting starts in one of two ways. Software can write the run bit, or a rising edge can arrive on an asynchronous external enable pin. When a start, a stop and a single-shot underflow land on the same clock, fixed priorities decide the outcome.

After a continuous-mode wrap, the counter reads as all ones for one clock and then settles to the reload value minus one. Software reaches the reload value, the counter, the control word and the output level through a small register bus.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset, all bus addresses read zero and the output pin is low: reload 0, counter 0, stopped, continuous mode, divide by 1.
- R2: A count tick occurs when the low bits of a free-running 3-bit cycle counter are all zero. The divider field selects how many bits: 0, 1, 2 or 3, giving one tick every 1, 2, 4 or 8 clocks. The counter changes only on a tick, or on a load, a wrap settle or a write as described in R3, R4 and R10.
- R3: The start clock is the clock on which the run state goes from stopped to running. On that clock the counter loads the reload value. It then decrements by one on each tick.
- R4: In continuous mode, a tick with counter 0 is an underflow. The counter becomes 16'hFFFF for exactly one clock and then the reload value minus 1. The output inverts at the underflow.
- R5: In single-shot mode, the mode in effect before a start is the one that applies. The output inverts on the start clock and again at the underflow. At the underflow the counter reloads and the timer stops. While the timer is stopped and no start occurs, the output does not change.
- R6: The external enable pin passes through two synchroniser flops and a rising-edge detector. A start takes effect on the third clock edge after the pin rises. A rising edge while the timer is running, or a pin held high, has no effect.
- R7: A control write with run bit 0 overrides a synchronised external rising edge on the same clock, so the timer ends up stopped.
- R8: In single-shot mode, an underflow stop overrides a synchronised external rising edge on the same clock, so the timer ends up stopped.
- R9: A control write with run bit 1 overrides a single-shot underflow stop on the same clock. The timer keeps running, and the output does not receive a start inversion.
- R10: A counter write loads the counter only while the timer is stopped. While the timer is running, a counter write is ignored.
- R11: Reads are registered: bus_rdata shows, one clock later, the value of the register selected by bus_addr. The address map is 0 reload, 1 counter, 2 control, 3 output level in bit 0. The control word has bit 0 run (reads back the resolved run state), bit 1 mode (1 = single-shot) and bits 3:2 divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register select for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_en | input | 1 | Asynchronous external start pin |
| tout | output | 1 | Toggling timer output |

## Verification
On every clock, the assertions check the following:
- the all-ones value after a continuous wrap;
- that the counter holds between ticks;
- the single-shot stop;
- that a software write wins over the other run-state sources;
- that the output is quiet while stopped;
- the single-clock width of the synchronised edge and the prescaler tick spacing.

Some behaviour only the bench scenarios can show, because it depends on lining up events across several clocks. This covers the settle to reload minus one, the three-edge latency of the external pin, and the exact coincidence of an external edge with a disable write or a single-shot underflow. A cycle-level reference model in the bench follows all of these under random bus traffic.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  typedef enum logic {
    MODE_CONT = 1'b0,
    MODE_SHOT = 1'b1
  } rt_mode_e;

  localparam logic [1:0] ADDR_RELOAD = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_OUT    = 2'd3;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_MODE_BIT = 1;
  localparam int unsigned CTRL_DIV_LSB  = 2;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      mask[i] = (i < int'(sel));
    end
    tick = ((pc_q & mask) == '0);
  end

  // a divided tick is never followed by another unless the divider changed
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0) |=> (!tick || sel != $past(sel)));  // R2
endmodule

// File: rtl/rt_edge_sync.sv
module rt_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;

  AST_RISE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);  // R6
endmodule

// File: rtl/rt_core.sv
module rt_core
  import reload_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  rt_mode_e         mode,
  input  logic             sw_wr,
  input  logic             sw_run,
  input  logic             ext_rise,
  input  logic [CNT_W-1:0] reload,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             tout_q
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ONES = '1;

  logic             pend_q, pend_d;
  logic             run_d, tout_d;
  logic [CNT_W-1:0] cnt_d;
  logic             uflow, shot_stop, start;

  always_comb begin
    uflow     = run_q && tick && !pend_q && (cnt_q == '0);
    shot_stop = uflow && (mode == MODE_SHOT);

    // run-state priority: software write, then single-shot stop, then pin
    run_d = run_q;
    if (sw_wr)          run_d = sw_run;
    else if (shot_stop) run_d = 1'b0;
    else if (ext_rise)  run_d = 1'b1;
    start = !run_q && run_d;

    cnt_d  = cnt_q;
    pend_d = 1'b0;
    if (start) begin
      cnt_d = reload;
    end else if (pend_q) begin
      cnt_d = reload - ONE;
    end else if (uflow) begin
      if (mode == MODE_CONT) begin
        cnt_d  = ONES;
        pend_d = 1'b1;
      end else begin
        cnt_d = reload;
      end
    end else if (run_q && tick) begin
      cnt_d = cnt_q - ONE;
    end else if (!run_q && cnt_wr) begin
      cnt_d = cnt_wdata;
    end

    tout_d = tout_q ^ (uflow | (start && (mode == MODE_SHOT)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      tout_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      tout_q <= tout_d;
      pend_q <= pend_d;
    end
  end

  AST_WRAP_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && cnt_q == '0 && mode == MODE_CONT) |=> (cnt_q == ONES));  // R4
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick && !pend_q) |=> (cnt_q == $past(cnt_q)));  // R2
  AST_SHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !pend_q && cnt_q == '0 && mode == MODE_SHOT && !sw_wr) |=> !run_q);  // R8
  AST_SW_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && !sw_run) |=> !run_q);  // R7
  AST_SW_ON_WINS: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_run) |=> run_q);  // R9
  AST_OUT_QUIET_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !(sw_wr && sw_run) && !ext_rise) |=> $stable(tout_q));  // R5
  AST_LOAD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !pend_q && cnt_wr && !ext_rise && !(sw_wr && sw_run)) |=> (cnt_q == $past(cnt_wdata)));  // R10
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_en,
  output logic              tout
);
  logic [CNT_W-1:0] reload_q;
  rt_mode_e         mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             tick, ext_rise, run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_ctrl, wr_cnt, wr_reload;
  logic [CNT_W-1:0] rd_mux;

  assign wr_ctrl   = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_cnt    = bus_we && (bus_addr == ADDR_W'(ADDR_COUNT));
  assign wr_reload = bus_we && (bus_addr == ADDR_W'(ADDR_RELOAD));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      mode_q   <= MODE_CONT;
      sel_q    <= '0;
    end else begin
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_ctrl) begin
        mode_q <= rt_mode_e'(bus_wdata[CTRL_MODE_BIT]);
        sel_q  <= bus_wdata[CTRL_DIV_LSB +: SEL_W];
      end
    end
  end

  rt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk (clk),
    .rst (rst),
    .sel (sel_q),
    .tick(tick)
  );

  rt_edge_sync u_sync (
    .clk (clk),
    .rst (rst),
    .pin (ext_en),
    .rise(ext_rise)
  );

  rt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode     (mode_q),
    .sw_wr    (wr_ctrl),
    .sw_run   (bus_wdata[CTRL_RUN_BIT]),
    .ext_rise (ext_rise),
    .reload   (reload_q),
    .cnt_wr   (wr_cnt),
    .cnt_wdata(bus_wdata),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .tout_q   (tout)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(ADDR_RELOAD): rd_mux = reload_q;
      ADDR_W'(ADDR_COUNT):  rd_mux = cnt_q;
      ADDR_W'(ADDR_CTRL): begin
        rd_mux[CTRL_RUN_BIT]               = run_q;
        rd_mux[CTRL_MODE_BIT]              = mode_q;
        rd_mux[CTRL_DIV_LSB +: SEL_W]      = sel_q;
      end
      default:              rd_mux[0] = tout;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_RDATA_HELD_IN_RESET: assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == '0));  // R1
endmodule

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        ext_en = 1'b0;
  logic        tout;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    cmp_on  = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  reload_timer u_reload_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_en(ext_en), .tout(tout)
  );

  // reference model, built from the requirements
  logic [15:0] m_cnt, m_rel, m_rdata;
  logic        m_run, m_mode, m_out, m_pend, m_s1, m_s2, m_s3;
  logic [1:0]  m_sel;
  logic [2:0]  m_pc;

  function automatic logic ref_tick(logic [2:0] pc, logic [1:0] sel);
    logic [2:0] mask = 3'((4'd1 << sel) - 4'd1);
    return (pc & mask) == 3'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_rdata = 0; m_run = 0; m_mode = 0; m_out = 0;
      m_pend = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_sel = 0; m_pc = 0;
    end else begin
      logic tk, rise, sww, uf, rn, st;
      logic [15:0] nc;
      tk   = ref_tick(m_pc, m_sel);
      rise = m_s2 & ~m_s3;
      sww  = bus_we && bus_addr == 2'd2;
      case (bus_addr)
        2'd0: m_rdata = m_rel;
        2'd1: m_rdata = m_cnt;
        2'd2: m_rdata = {12'd0, m_sel, m_mode, m_run};
        default: m_rdata = {15'd0, m_out};
      endcase
      uf = m_run && tk && !m_pend && m_cnt == 16'd0;
      rn = m_run;
      if (sww) rn = bus_wdata[0];
      else if (uf && m_mode) rn = 1'b0;
      else if (rise) rn = 1'b1;
      st = !m_run && rn;
      nc = m_cnt;
      if (st) nc = m_rel;
      else if (m_pend) nc = m_rel - 16'd1;
      else if (uf) nc = m_mode ? m_rel : 16'hFFFF;
      else if (m_run && tk) nc = m_cnt - 16'd1;
      else if (!m_run && bus_we && bus_addr == 2'd1) nc = bus_wdata;
      m_out  = m_out ^ (uf | (st & m_mode));
      m_pend = uf && !m_mode && !st;
      m_cnt  = nc;
      m_run  = rn;
      if (bus_we && bus_addr == 2'd0) m_rel = bus_wdata;
      if (sww) begin m_mode = bus_wdata[1]; m_sel = bus_wdata[3:2]; end
      m_pc = m_pc + 3'd1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_en;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (cmp_on) begin
      chk({cur_req, " rdata"}, bus_rdata, m_rdata);
      chk({cur_req, " tout"}, {15'd0, tout}, {15'd0, m_out});
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic o0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R1: reset values on every address
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      step();
      chk("R1 reset read", bus_rdata, 16'd0);
    end
    chk("R1 reset tout", {15'd0, tout}, 16'd0);

    // R4: continuous wrap shows FFFF then reload-1
    cur_req = "R4";
    wr(2'd0, 16'd3);
    wr(2'd2, 16'h0001);
    bus_addr = 2'd1;
    o0 = tout;
    idle(5);
    chk("R4 wrap value", bus_rdata, 16'hFFFF);
    chk("R4 toggle", {15'd0, tout}, {15'd0, ~o0});
    step();
    chk("R4 settle", bus_rdata, 16'd2);
    wr(2'd2, 16'h0000);
    idle(4);

    // R7: disable write coincides with synchronised pin edge
    cur_req = "R7";
    ext_en = 1'b1;
    idle(2);
    wr(2'd2, 16'h0000);
    step();
    chk("R7 run after conflict", {15'd0, bus_rdata[0]}, 16'd0);
    ext_en = 1'b0;
    idle(4);

    // R6 R3: pin start latency, then countdown; held pin does not restart
    cur_req = "R6";
    wr(2'd0, 16'd10);
    ext_en = 1'b1;
    bus_addr = 2'd1;
    idle(4);
    chk("R6 start load", bus_rdata, 16'd10);
    step();
    chk("R3 decrement", bus_rdata, 16'd9);
    idle(3);
    wr(2'd2, 16'h0000);
    idle(4);
    bus_addr = 2'd2;
    step();
    chk("R6 held pin no restart", {15'd0, bus_rdata[0]}, 16'd0);
    ext_en = 1'b0;
    idle(4);

    // R8: single-shot underflow coincides with pin edge
    cur_req = "R8";
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'd4);
    o0 = tout;
    wr(2'd2, 16'h0003);
    idle(2);
    ext_en = 1'b1;
    bus_addr = 2'd2;
    idle(4);
    chk("R8 stopped", {15'd0, bus_rdata[0]}, 16'd0);
    bus_addr = 2'd1;
    step();
    chk("R5 reload after shot", bus_rdata, 16'd4);
    chk("R5 single pulse", {15'd0, tout}, {15'd0, o0});
    ext_en = 1'b0;
    idle(4);

    // R9: enable write coincides with single-shot underflow
    cur_req = "R9";
    o0 = tout;
    wr(2'd2, 16'h0003);
    idle(4);
    wr(2'd2, 16'h0003);
    step();
    chk("R9 still running", {15'd0, bus_rdata[0]}, 16'd1);
    chk("R9 no start toggle", {15'd0, tout}, {15'd0, o0});
    wr(2'd2, 16'h0002);
    idle(3);

    // R10: counter write stopped vs running
    cur_req = "R10";
    wr(2'd1, 16'h1234);
    bus_addr = 2'd1;
    step();
    chk("R10 load stopped", bus_rdata, 16'h1234);
    wr(2'd0, 16'h0100);
    wr(2'd2, 16'h000D);
    wr(2'd1, 16'h0055);
    bus_addr = 2'd1;
    step();
    chk("R10 ignored running", {15'd0, bus_rdata >= 16'h00F0}, 16'd1);
    wr(2'd2, 16'h0000);
    idle(3);

    // R2 R3 R5 R6 R11: random traffic against the reference model
    cur_req = "R2 R3 R5 R6 R11 random";
    for (int i = 0; i < 4000; i++) begin
      bus_we   = ($urandom % 8) == 0;
      bus_addr = 2'($urandom % 4);
      bus_wdata = (bus_addr == 2'd2) ? 16'($urandom % 16) : 16'($urandom % 64);
      if (($urandom % 16) == 0) ext_en = ~ext_en;
      step();
    end
    bus_we = 1'b0;
    idle(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule